// File: doc/BRIEF.md
# Interrupt Loop Detector

This block watches a processor's interrupt traffic and spots a handler that is entered again and again without a proper return. It covers three interrupt classes: program, external and I/O. Each class owns two flag bits, a plain bit and a strong bit. Accepting an interrupt of a class sets both of that class's bits. Every reload of the program status word clears all the plain bits. A reload taken from a class's own old-PSW save slot also clears that class's strong bit.

Each accept is classified using the two bits of its class. If both are still set, the handler never reloaded its status, and this is a fatal weak loop, so the block raises a halt request that stays set. If only one is set, the handler reloaded its status but not from its own save slot, and this is a tolerated strong loop. A strong loop is only reported, with no halt.

The surrounding core drives the strobes once per event. It reads the flag byte, the one-cycle loop pulses with the offending class, and the halt request.

Top module: `ild_loop_detector`

## Requirements
- R1: While reset is active, and in the first cycle after reset, the flag byte, both loop pulses, the loop class and the halt request are all zero.
- R2: Flag byte layout: bit 0 program plain, bit 1 program strong, bit 2 external plain, bit 3 external strong, bit 4 I/O plain, bit 5 I/O strong. Bits 6 and 7 always read zero. Class codes are 0 program, 1 external and 2 I/O.
- R3: An accept with a valid class code sets both bits of that class at the next clock edge.
- R4: Any status reload clears bits 0, 2 and 4 at the next clock edge.
- R5: A status reload flagged as coming from the old-PSW slot of class c also clears the strong bit of class c, and no other strong bit.
- R6: An accept whose class has both bits set produces a weak pulse for exactly one cycle after the edge, with the loop class equal to the accepted class, and sets the halt request.
- R7: An accept whose class has exactly one bit set produces a strong pulse for one cycle with the class, and does not raise the halt request.
- R8: An accept whose class has neither bit set produces no pulse. When no pulse is present, the loop class reads 0.
- R9: When a reload and an accept arrive in the same cycle, the reload clearing is applied first. The classification and the setting of the bits then use the cleared values.
- R10: Once set, the halt request stays at 1 until reset.
- R11: Class code 3 is ignored. An accept with code 3 changes no bit and gives no pulse. A reload with code 3 and the old-slot flag set clears only the plain bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Interrupt accepted this cycle |
| acc_cls | input | 2 | Class code of the accepted interrupt |
| lpsw_vld | input | 1 | Status word reloaded this cycle |
| lpsw_old | input | 1 | Reload came from a class's old-PSW slot |
| lpsw_cls | input | 2 | Class whose old-PSW slot was used |
| flags | output | 8 | Loop flag byte |
| weak_loop | output | 1 | One-cycle weak loop pulse |
| strong_loop | output | 1 | One-cycle strong loop pulse |
| loop_cls | output | 2 | Class of the reported loop, 0 when idle |
| halt_req | output | 1 | Sticky halt request |

## Verification
Every output is registered. A strobe presented before a clock edge therefore shows its effect on the flags, the pulses, the loop class and the halt request right after that same edge, with a latency of exactly one cycle. The bench drives its inputs on the falling edge and samples all outputs on the following falling edge, one rising edge later. It keeps an arithmetic model of the flag byte that is stepped once per cycle, so each comparison lines up with that single-cycle latency. A pulse expected in cycle n is checked to be absent again in cycle n+1.

// File: rtl/ild_pkg.sv
package ild_pkg;
   typedef enum logic [1:0] {
      ILD_CLS_PROG = 2'd0,
      ILD_CLS_EXT  = 2'd1,
      ILD_CLS_IO   = 2'd2,
      ILD_CLS_NONE = 2'd3
   } ild_cls_e;

   // position of the plain bit of a class inside the flag byte
   function automatic int unsigned plain_pos(input int unsigned cls);
      return 2 * cls;
   endfunction
endpackage

// File: rtl/ild_class_slice.sv
// Next-state logic and classification for the flag pair of one class.
module ild_class_slice (
   input  logic [1:0] pair_q,     // [0] plain, [1] strong
   input  logic       acc_hit,
   input  logic       clr_plain,
   input  logic       clr_strong,
   output logic [1:0] pair_d,
   output logic       weak_hit,
   output logic       strong_hit
);
   logic [1:0] mid;

   always_comb begin
      // reload clearing comes first
      mid[0] = pair_q[0] & ~clr_plain;
      mid[1] = pair_q[1] & ~clr_strong;
      weak_hit   = acc_hit & mid[0] & mid[1];
      strong_hit = acc_hit & (mid[0] ^ mid[1]);
      pair_d     = acc_hit ? 2'b11 : mid;
   end
endmodule

// File: rtl/ild_event_reduce.sv
// Collapses per-class hits into single loop indications.
module ild_event_reduce #(
   parameter int unsigned NUM_CLS = 3
) (
   input  logic [NUM_CLS-1:0] weak_vec,
   input  logic [NUM_CLS-1:0] strong_vec,
   output logic               any_weak,
   output logic               any_strong
);
   always_comb begin
      any_weak   = |weak_vec;
      any_strong = |strong_vec;
   end
endmodule

// File: rtl/ild_loop_detector.sv
module ild_loop_detector #(
   parameter int unsigned NUM_CLS = 3,
   parameter int unsigned CLS_W   = 2,
   parameter int unsigned FLAG_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_vld,
   input  logic [CLS_W-1:0] acc_cls,
   input  logic             lpsw_vld,
   input  logic             lpsw_old,
   input  logic [CLS_W-1:0] lpsw_cls,
   output logic [FLAG_W-1:0] flags,
   output logic             weak_loop,
   output logic             strong_loop,
   output logic [CLS_W-1:0] loop_cls,
   output logic             halt_req
);
   import ild_pkg::*;

   localparam int unsigned USED_W = 2 * NUM_CLS;

   generate
      if (FLAG_W < USED_W) begin : g_bad_width
         $error("FLAG_W too small for NUM_CLS flag pairs");
      end
      if ((1 << CLS_W) <= NUM_CLS) begin : g_bad_code
         $error("CLS_W leaves no spare class code");
      end
   endgenerate

   logic [FLAG_W-1:0]  flags_q, flags_d;
   logic [NUM_CLS-1:0] weak_vec, strong_vec;
   logic               any_weak, any_strong;
   logic               weak_q, strong_q, halt_q;
   logic [CLS_W-1:0]   cls_q;

   generate
      for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
         logic acc_hit, old_hit;
         assign acc_hit = acc_vld & (acc_cls == CLS_W'(i));
         assign old_hit = lpsw_vld & lpsw_old & (lpsw_cls == CLS_W'(i));
         ild_class_slice u_slice (
            .pair_q     (flags_q[plain_pos(i) +: 2]),
            .acc_hit    (acc_hit),
            .clr_plain  (lpsw_vld),
            .clr_strong (old_hit),
            .pair_d     (flags_d[plain_pos(i) +: 2]),
            .weak_hit   (weak_vec[i]),
            .strong_hit (strong_vec[i])
         );
      end
      if (FLAG_W > USED_W) begin : g_spare
         assign flags_d[FLAG_W-1:USED_W] = '0;
      end
   endgenerate

   ild_event_reduce #(.NUM_CLS(NUM_CLS)) u_reduce (
      .weak_vec   (weak_vec),
      .strong_vec (strong_vec),
      .any_weak   (any_weak),
      .any_strong (any_strong)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q  <= '0;
         weak_q   <= 1'b0;
         strong_q <= 1'b0;
         cls_q    <= '0;
         halt_q   <= 1'b0;
      end else begin
         flags_q  <= flags_d;
         weak_q   <= any_weak;
         strong_q <= any_strong;
         cls_q    <= (any_weak | any_strong) ? acc_cls : '0;
         halt_q   <= halt_q | any_weak;
      end
   end

   assign flags       = flags_q;
   assign weak_loop   = weak_q;
   assign strong_loop = strong_q;
   assign loop_cls    = cls_q;
   assign halt_req    = halt_q;
endmodule

// File: rtl/ild_loop_detector_chk.sv
module ild_loop_detector_chk #(
   parameter int unsigned NUM_CLS = 3,
   parameter int unsigned CLS_W   = 2,
   parameter int unsigned FLAG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_vld,
   input logic [CLS_W-1:0]  acc_cls,
   input logic              lpsw_vld,
   input logic              lpsw_old,
   input logic [CLS_W-1:0]  lpsw_cls,
   input logic [FLAG_W-1:0] flags,
   input logic              weak_loop,
   input logic              strong_loop,
   input logic [CLS_W-1:0]  loop_cls,
   input logic              halt_req
);
   localparam int unsigned USED_W = 2 * NUM_CLS;

   generate
      if (FLAG_W > USED_W) begin : g_spare
         assert_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            flags[FLAG_W-1:USED_W] == '0);
      end
      for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
         assert_accept_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            acc_vld && acc_cls == CLS_W'(i) |=> flags[2*i +: 2] == 2'b11);
         assert_plain_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
            lpsw_vld && !acc_vld |=> !flags[2*i]);
         assert_old_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            lpsw_vld && lpsw_old && lpsw_cls == CLS_W'(i) && !acc_vld |=> !flags[2*i+1]);
      end
   endgenerate

   assert_weak_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      weak_loop |-> halt_req);
   assert_pulse_needs_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_vld |=> !weak_loop && !strong_loop && loop_cls == '0);
   assert_one_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(weak_loop && strong_loop));
   assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |=> halt_req);
endmodule

bind ild_loop_detector ild_loop_detector_chk #(
   .NUM_CLS(NUM_CLS), .CLS_W(CLS_W), .FLAG_W(FLAG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_cls(acc_cls),
   .lpsw_vld(lpsw_vld), .lpsw_old(lpsw_old), .lpsw_cls(lpsw_cls),
   .flags(flags), .weak_loop(weak_loop), .strong_loop(strong_loop),
   .loop_cls(loop_cls), .halt_req(halt_req)
);

// File: tb/ild_loop_detector_bench.sv
`timescale 1ns/1ps
module ild_loop_detector_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_vld = 1'b0, lpsw_vld = 1'b0, lpsw_old = 1'b0;
   logic [1:0] acc_cls = 2'd0, lpsw_cls = 2'd0;
   logic [7:0] flags;
   logic       weak_loop, strong_loop, halt_req;
   logic [1:0] loop_cls;

   int n_chk = 0, n_bad = 0;
   logic [7:0] m_flags;
   logic       m_weak, m_strong, m_halt;
   logic [1:0] m_cls;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   ild_loop_detector u_ild_loop_detector (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_cls(acc_cls),
      .lpsw_vld(lpsw_vld), .lpsw_old(lpsw_old), .lpsw_cls(lpsw_cls),
      .flags(flags), .weak_loop(weak_loop), .strong_loop(strong_loop),
      .loop_cls(loop_cls), .halt_req(halt_req)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk({tag, " flags"}, flags, m_flags);
      chk({tag, " weak"}, weak_loop, m_weak);
      chk({tag, " strong"}, strong_loop, m_strong);
      chk({tag, " cls"}, loop_cls, m_cls);
      chk({tag, " halt"}, halt_req, m_halt);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; acc_vld = 0; lpsw_vld = 0; lpsw_old = 0;
      @(posedge clk); @(negedge clk);
      m_flags = 0; m_weak = 0; m_strong = 0; m_cls = 0; m_halt = 0;
      compare_all("R1 in reset");
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      compare_all("R1 after reset");
   endtask

   // one cycle: drive at negedge, update model, sample at next negedge
   task automatic step(input string tag, input bit av, input logic [1:0] ac,
                       input bit lv, input bit lo, input logic [1:0] lc);
      logic [1:0] pr;
      acc_vld = av; acc_cls = ac; lpsw_vld = lv; lpsw_old = lo; lpsw_cls = lc;
      if (lv) begin m_flags[0] = 0; m_flags[2] = 0; m_flags[4] = 0; end
      if (lv && lo && lc != 2'd3) m_flags[2*lc+1] = 0;
      m_weak = 0; m_strong = 0; m_cls = 0;
      if (av && ac != 2'd3) begin
         pr = m_flags[2*ac +: 2];
         m_weak = &pr; m_strong = ^pr;
         if (m_weak || m_strong) m_cls = ac;
         m_flags[2*ac +: 2] = 2'b11;
      end
      m_halt = m_halt | m_weak;
      @(posedge clk); @(negedge clk);
      acc_vld = 0; lpsw_vld = 0; lpsw_old = 0;
      compare_all(tag);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // directed cases
      step("R3 prog set", 1, 2'd0, 0, 0, 0);
      chk("R3 prog bits", flags, 8'h03);
      step("R6 weak prog", 1, 2'd0, 0, 0, 0);
      chk("R6 weak pulse", weak_loop, 1); chk("R6 halt", halt_req, 1);
      step("R6 pulse ends", 0, 0, 0, 0, 0);
      chk("R6 one cycle", weak_loop, 0);
      step("R10 halt holds", 0, 0, 1, 1, 2'd0);
      chk("R10 sticky", halt_req, 1);
      do_reset();
      step("R8 ext first", 1, 2'd1, 0, 0, 0);
      chk("R8 no pulse", weak_loop | strong_loop, 0);
      step("R4 reload", 0, 0, 1, 0, 0);
      chk("R4 plain cleared", flags, 8'h08);
      step("R7 strong ext", 1, 2'd1, 0, 0, 0);
      chk("R7 strong pulse", strong_loop, 1); chk("R7 cls", loop_cls, 1);
      chk("R7 no halt", halt_req, 0);
      step("R5 old ext", 0, 0, 1, 1, 2'd1);
      chk("R5 cleared", flags, 8'h00);
      step("R3 io set", 1, 2'd2, 0, 0, 0);
      step("R9 same cycle", 1, 2'd2, 1, 1, 2'd2);
      chk("R9 no pulse", weak_loop | strong_loop, 0);
      chk("R9 flags", flags, 8'h30);
      step("R11 code3 accept", 1, 2'd3, 0, 0, 0);
      chk("R11 unchanged", flags, 8'h30);
      step("R11 code3 reload", 0, 0, 1, 1, 2'd3);
      chk("R11 strong kept", flags, 8'h20);
      step("R2 strong io", 1, 2'd2, 0, 0, 0);
      chk("R2 cls io", loop_cls, 2);
      chk("R2 spare bits", flags[7:6], 0);
      // near-exhaustive sweep of all strobe combinations
      do_reset();
      for (int r = 0; r < 6; r++) begin
         for (int k = 0; k < 128; k++) begin
            int j;
            j = (k * 37 + r * 11) % 128;
            step("R2 R3 R4 R5 R6 R7 R8 R9 R11 sweep", j[0], j[2:1], j[3], j[4], j[6:5]);
         end
         if (r == 2) do_reset();
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule